// File: doc/BRIEF.md
# Paged Network Controller Register File

This block is the byte-wide host register front end of a small Ethernet controller. Software reaches sixteen byte offsets. Offset 0 is always the command register. The top two bits of the command register pick one of four register pages, and that page decides what offsets 1 to 15 mean. A write and a read at the same offset can reach different registers. The block holds the receive ring pointers, the transmit page and length, the remote DMA address and length, the receive and data configuration bytes, the station address, the multicast hash, and the interrupt status and mask registers.

The frame data path around the block reports its events through a set-only input. The block combines those events with the mask into one level interrupt. When software issues a transmit command, the block raises a one-cycle transmit request and completes the transmit handshake in its status registers. Ring pointer writes that would point past the end of the buffer memory are dropped. This keeps the data path from being aimed outside its storage. The write-only registers are driven out as ports for the neighbouring logic.

Top module: `nic_regfile`

## Requirements
- R1: After reset, the command register reads 0x21, the interrupt status reads 0x80, the mask is 0x00, and `irq` and `tx_req` are low.
- R2: The effective index is {command[7:6], offset}. Offset 0 reads and writes the command register on every page. Page 1 holds station address bytes 0 to 5 at offsets 1 to 6 (byte n on `station_addr[8n+7:8n]`), the current page at offset 7, and hash bytes 0 to 7 at offsets 8 to 15 (byte n on `mcast_hash[8n+7:8n]`), all readable and writable. Page 2 reads the ring start at offset 1 and the ring stop at offset 2. Writes to pages 2 and 3 are ignored, and unmapped reads return 0x00.
- R3: `irq` is high exactly when (status & mask & 0x7F) is nonzero. Status bit 7 (reset done) never raises it.
- R4: Status bits are 0 rx ok, 1 tx ok, 2 rx error, 3 tx error, 4 ring overwrite, 5 counter overflow, 6 remote DMA done, 7 reset done. A page-0 write at offset 7 clears each of bits 6..0 where the written byte holds a 1, and never clears bit 7. Each `evt_set` bit sets its status bit, and a set wins over a clear in the same cycle.
- R5: A command write with bit 0 clear clears status bit 7. A command write with bit 0 set leaves status bit 7 unchanged.
- R6: A command write with bit 0 clear and bit 3 or bit 4 set, while the remote DMA count is zero, sets status bit 6. It does not set bit 6 when the count is nonzero.
- R7: A command write with bit 2 set and bit 0 clear drives `tx_req` high for exactly the cycle after the write. It also sets the transmit status (page 0 offset 4) to 0x01, sets status bit 1, and stores the command with bit 2 cleared. With bit 0 set, no request is made and the byte is stored as written.
- R8: With the buffer end at BUF_END_PAGE×256, a ring start write (page 0 offset 1) or ring stop write (offset 2) is ignored when value > BUF_END_PAGE. A boundary write (page 0 offset 3) or current page write (page 1 offset 7) is ignored when value >= BUF_END_PAGE.
- R9: The transmit count (page 0 offsets 5 low, 6 high), remote address (8 low, 9 high) and remote count (10 low, 11 high) are 16 bits wide. Each byte write replaces only its own half. The remote address reads back on page 0 at offsets 8 and 9.
- R10: On page 0, offset 4 writes the transmit page, 12 the receive configuration, 14 the data configuration and 15 the mask. Offset 3 reads the boundary and offset 7 reads the status. Page-0 read offsets 1, 2, 5, 6 and 10 to 15 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| evt_set | input | 8 | Per-bit status set requests from the data path |
| irq | output | 1 | Level interrupt |
| tx_req | output | 1 | One-cycle transmit request |
| ring_start | output | 8 | Ring start page |
| ring_stop | output | 8 | Ring stop page |
| ring_bound | output | 8 | Ring boundary page |
| cur_page | output | 8 | Current receive page |
| tx_page | output | 8 | Transmit start page |
| tx_count | output | 16 | Transmit byte count |
| rdma_addr | output | 16 | Remote DMA address |
| rdma_count | output | 16 | Remote DMA byte count |
| rx_cfg | output | 8 | Receive configuration |
| data_cfg | output | 8 | Data configuration |
| station_addr | output | 48 | Station address bytes |
| mcast_hash | output | 64 | Multicast hash bytes |

## Verification
The hardest case to reach is a collision on the status register. In that case a data-path event and a software clear of the same bit land in one cycle, and the set has to survive. The bench drives `evt_set` and the offset 7 write on the same clock edge. It also raises the reset-done bit again through `evt_set` after software has cleared it, so it can show that a write of all ones cannot clear that bit. The page-dependent behaviour is covered by a walk through a vector table. The walk changes page between rows, so each result depends on the command byte left by earlier rows.

// File: rtl/nic_regfile.sv
module nic_regfile #(
  parameter int BUF_END_PAGE = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [7:0]  evt_set,
  output logic        irq,
  output logic        tx_req,
  output logic [7:0]  ring_start,
  output logic [7:0]  ring_stop,
  output logic [7:0]  ring_bound,
  output logic [7:0]  cur_page,
  output logic [7:0]  tx_page,
  output logic [15:0] tx_count,
  output logic [15:0] rdma_addr,
  output logic [15:0] rdma_count,
  output logic [7:0]  rx_cfg,
  output logic [7:0]  data_cfg,
  output logic [47:0] station_addr,
  output logic [63:0] mcast_hash
);
  localparam int STA_BYTES  = 6;
  localparam int HASH_BYTES = 8;
  localparam logic [8:0] END_P = 9'(BUF_END_PAGE);

  logic [7:0] cmd_q, isr_q, imr_q, tsr_q, isr_nx;
  logic [7:0] sta  [STA_BYTES];
  logic [7:0] hash [HASH_BYTES];
  logic [5:0] idx;
  logic wr_cmd, wr_reg, go_tx, dma_kick, wide_ok, narrow_ok;

  assign idx       = {cmd_q[7:6], reg_addr};
  assign wr_cmd    = reg_wr && (reg_addr == 4'h0);
  assign wr_reg    = reg_wr && (reg_addr != 4'h0);
  assign go_tx     = wr_cmd && !reg_wdata[0] && reg_wdata[2];
  assign dma_kick  = wr_cmd && !reg_wdata[0] && (reg_wdata[3] || reg_wdata[4])
                     && (rdma_count == 16'h0);
  assign wide_ok   = {1'b0, reg_wdata} <= END_P;
  assign narrow_ok = {1'b0, reg_wdata} <  END_P;
  assign irq       = |(isr_q[6:0] & imr_q[6:0]);

  genvar g;
  generate
    for (g = 0; g < STA_BYTES; g++) begin : g_sta
      assign station_addr[8*g +: 8] = sta[g];
    end
    for (g = 0; g < HASH_BYTES; g++) begin : g_hash
      assign mcast_hash[8*g +: 8] = hash[g];
    end
  endgenerate

  always_comb begin
    isr_nx = isr_q;
    if (wr_reg && idx == 6'h07) isr_nx = isr_nx & ~{1'b0, reg_wdata[6:0]};
    if (wr_cmd && !reg_wdata[0]) isr_nx[7] = 1'b0;
    if (dma_kick) isr_nx[6] = 1'b1;
    if (go_tx)    isr_nx[1] = 1'b1;
    isr_nx = isr_nx | evt_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q      <= 8'h21;
      isr_q      <= 8'h80;
      imr_q      <= 8'h00;
      tsr_q      <= 8'h00;
      tx_req     <= 1'b0;
      ring_start <= 8'h00;
      ring_stop  <= 8'h00;
      ring_bound <= 8'h00;
      cur_page   <= 8'h00;
      tx_page    <= 8'h00;
      tx_count   <= 16'h0;
      rdma_addr  <= 16'h0;
      rdma_count <= 16'h0;
      rx_cfg     <= 8'h00;
      data_cfg   <= 8'h00;
      for (int i = 0; i < STA_BYTES; i++)  sta[i]  <= 8'h00;
      for (int i = 0; i < HASH_BYTES; i++) hash[i] <= 8'h00;
    end else begin
      isr_q  <= isr_nx;
      tx_req <= go_tx;
      if (wr_cmd) cmd_q <= go_tx ? (reg_wdata & 8'hFB) : reg_wdata;
      if (go_tx) tsr_q <= 8'h01;
      if (wr_reg) begin
        case (idx)
          6'h01: if (wide_ok)   ring_start <= reg_wdata;
          6'h02: if (wide_ok)   ring_stop  <= reg_wdata;
          6'h03: if (narrow_ok) ring_bound <= reg_wdata;
          6'h04: tx_page          <= reg_wdata;
          6'h05: tx_count[7:0]    <= reg_wdata;
          6'h06: tx_count[15:8]   <= reg_wdata;
          6'h08: rdma_addr[7:0]   <= reg_wdata;
          6'h09: rdma_addr[15:8]  <= reg_wdata;
          6'h0A: rdma_count[7:0]  <= reg_wdata;
          6'h0B: rdma_count[15:8] <= reg_wdata;
          6'h0C: rx_cfg           <= reg_wdata;
          6'h0E: data_cfg         <= reg_wdata;
          6'h0F: imr_q            <= reg_wdata;
          6'h11, 6'h12, 6'h13, 6'h14, 6'h15, 6'h16:
                 sta[3'(reg_addr[2:0] - 3'd1)] <= reg_wdata;
          6'h17: if (narrow_ok) cur_page <= reg_wdata;
          6'h18, 6'h19, 6'h1A, 6'h1B, 6'h1C, 6'h1D, 6'h1E, 6'h1F:
                 hash[reg_addr[2:0]] <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == 4'h0) begin
      reg_rdata = cmd_q;
    end else begin
      case (idx)
        6'h03: reg_rdata = ring_bound;
        6'h04: reg_rdata = tsr_q;
        6'h07: reg_rdata = isr_q;
        6'h08: reg_rdata = rdma_addr[7:0];
        6'h09: reg_rdata = rdma_addr[15:8];
        6'h11, 6'h12, 6'h13, 6'h14, 6'h15, 6'h16:
               reg_rdata = sta[3'(reg_addr[2:0] - 3'd1)];
        6'h17: reg_rdata = cur_page;
        6'h18, 6'h19, 6'h1A, 6'h1B, 6'h1C, 6'h1D, 6'h1E, 6'h1F:
               reg_rdata = hash[reg_addr[2:0]];
        6'h21: reg_rdata = ring_start;
        6'h22: reg_rdata = ring_stop;
        default: reg_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/nic_regfile_chk.sv
module nic_regfile_chk #(
  parameter int BUF_END_PAGE = 128
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [3:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic [7:0]  evt_set,
  input logic        irq,
  input logic        tx_req,
  input logic [7:0]  ring_start,
  input logic [7:0]  cur_page,
  input logic [15:0] rdma_count,
  input logic [7:0]  cmd_q,
  input logic [7:0]  isr_q,
  input logic [7:0]  imr_q
);
  localparam logic [8:0] END_P = 9'(BUF_END_PAGE);

  logic cmd_go, stat_wr, start_wr_ok;
  assign cmd_go      = reg_wr && reg_addr == 4'h0 && !reg_wdata[0];
  assign stat_wr     = reg_wr && reg_addr == 4'h7 && cmd_q[7:6] == 2'b00;
  assign start_wr_ok = reg_wr && reg_addr == 4'h1 && cmd_q[7:6] == 2'b00
                       && {1'b0, reg_wdata} <= END_P;

  assert_bit7_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q == 8'h80) |-> !irq);
  assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (isr_q[6:0] != 7'h0 && imr_q[6:0] != 7'h0));
  assert_clear_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((isr_q[6:0] & $past(reg_wdata[6:0] & ~evt_set[6:0])) == 7'h0));
  assert_reset_done_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !evt_set[7]) |=> !isr_q[7]);
  assert_zero_len_dma_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && (reg_wdata[3] || reg_wdata[4]) && rdma_count == 16'h0) |=> isr_q[6]);
  assert_tx_handshake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && reg_wdata[2]) |=> (tx_req && isr_q[1] && !cmd_q[2]));
  assert_tx_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(cmd_go && reg_wdata[2]));
  assert_start_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ring_start) |-> $past(start_wr_ok));
  assert_curpage_below_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cur_page} < END_P);
endmodule

bind nic_regfile nic_regfile_chk #(.BUF_END_PAGE(BUF_END_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .evt_set(evt_set), .irq(irq), .tx_req(tx_req),
  .ring_start(ring_start), .cur_page(cur_page), .rdma_count(rdma_count),
  .cmd_q(cmd_q), .isr_q(isr_q), .imr_q(imr_q)
);

// File: tb/nic_regfile_bench.sv
module nic_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [7:0]  evt_set;
  logic        irq, tx_req;
  logic [7:0]  ring_start, ring_stop, ring_bound, cur_page, tx_page, rx_cfg, data_cfg;
  logic [15:0] tx_count, rdma_addr, rdma_count;
  logic [47:0] station_addr;
  logic [63:0] mcast_hash;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  nic_regfile #(.BUF_END_PAGE(128)) u_nic_regfile (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .irq(irq), .tx_req(tx_req), .ring_start(ring_start), .ring_stop(ring_stop),
    .ring_bound(ring_bound), .cur_page(cur_page), .tx_page(tx_page),
    .tx_count(tx_count), .rdma_addr(rdma_addr), .rdma_count(rdma_count),
    .rx_cfg(rx_cfg), .data_cfg(data_cfg), .station_addr(station_addr),
    .mcast_hash(mcast_hash)
  );

  // {write offset, write data, read offset, expected, requirement number}
  localparam logic [31:0] VEC [26] = '{
    32'h0210_2102,  // R2 page 0 command readback
    32'h1403_000A,  // R10 boundary reset value
    32'h3463_460A,  // R10 boundary write/read
    32'h3803_4608,  // R8 boundary at end ignored
    32'h37F3_7F08,  // R8 boundary just below end
    32'h8348_3409,  // R9 remote address low
    32'h9129_1209,  // R9 remote address high
    32'h8AB9_1209,  // R9 low write keeps high half
    32'h8CD8_CD09,  // R9 low replaced
    32'h2800_2108,  // R8 stop equal to end accepted
    32'h1810_2108,  // R8 start above end ignored
    32'h0610_6102,  // R2 select page 1
    32'h1111_1102,  // R2 station byte 0
    32'h6666_6602,  // R2 station byte 5
    32'h7807_0008,  // R8 current page at end ignored
    32'h77F7_7F08,  // R8 current page below end
    32'h8A58_A502,  // R2 hash byte 0
    32'hF5AF_5A02,  // R2 hash byte 7
    32'h3993_9902,  // R2 station byte 2
    32'h0A11_4008,  // R8 page 2 start readback
    32'h0A12_8008,  // R8 page 2 stop readback
    32'h5555_0002,  // R2 page 2 write ignored, unmapped read
    32'h0E1F_0002,  // R2 page 3 reads zero
    32'h0213_7F0A,  // R10 boundary intact after paging
    32'h0211_000A,  // R10 page 0 offset 1 reads zero
    32'h0217_8005   // R5 stop-set commands keep reset done
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_evt(input logic [3:0] a, input logic [7:0] d, input logic [7:0] e);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; evt_set = e;
    @(negedge clk);
    reg_wr = 1'b0; evt_set = 8'h00;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_evt(a, d, 8'h00);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] q);
    @(negedge clk);
    reg_addr = a;
    #1 q = reg_rdata;
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    @(negedge clk);
    evt_set = e;
    @(negedge clk);
    evt_set = 8'h00;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_addr = 4'h0; reg_wr = 1'b0; reg_wdata = 8'h00; evt_set = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, v); check("R1 command", v, 8'h21);
    rd(4'h7, v); check("R1 status", v, 8'h80);
    check("R1 irq", irq, 1'b0);
    check("R1 tx_req", tx_req, 1'b0);

    foreach (VEC[i]) begin
      wr(VEC[i][31:28], VEC[i][27:20]);
      rd(VEC[i][19:16], v);
      check($sformatf("R%0d row %0d", VEC[i][7:0], i), v, VEC[i][15:8]);
    end

    // R8 / R2 outputs left by the table
    check("R8 ring_start", ring_start, 8'h40);
    check("R8 ring_stop", ring_stop, 8'h80);
    check("R8 cur_page", cur_page, 8'h7F);
    check("R2 station byte0", station_addr[7:0], 8'h11);
    check("R2 station byte2", station_addr[23:16], 8'h99);
    check("R2 station byte5", station_addr[47:40], 8'h66);
    check("R2 hash byte0", mcast_hash[7:0], 8'hA5);
    check("R2 hash byte7", mcast_hash[63:56], 8'h5A);
    check("R9 rdma_addr", rdma_addr, 16'h12CD);

    // R3 reset-done bit is masked out of irq
    wr(4'hF, 8'hFF);
    check("R3 bit7 no irq", irq, 1'b0);
    // R5 stop clear drops reset done
    wr(4'h0, 8'h22);
    rd(4'h7, v); check("R5 status after start", v, 8'h00);

    // R6 zero-length remote transfer
    wr(4'hA, 8'h00); wr(4'hB, 8'h00);
    wr(4'h0, 8'h0A);
    rd(4'h7, v); check("R6 dma done set", v, 8'h40);
    check("R3 irq on dma done", irq, 1'b1);
    wr(4'h7, 8'h40);
    rd(4'h7, v); check("R4 clear dma done", v, 8'h00);
    check("R3 irq low after clear", irq, 1'b0);
    wr(4'hA, 8'h05);
    check("R9 rdma_count low", rdma_count, 16'h0005);
    wr(4'h0, 8'h12);
    rd(4'h7, v); check("R6 nonzero count no done", v, 8'h00);

    // R9 transmit count halves, R10 tx page
    wr(4'h5, 8'h34); wr(4'h6, 8'h12);
    check("R9 tx_count", tx_count, 16'h1234);
    wr(4'h5, 8'hFF);
    check("R9 tx_count low only", tx_count, 16'h12FF);
    wr(4'h4, 8'h40);
    check("R10 tx_page", tx_page, 8'h40);

    // R7 transmit command
    wr(4'h0, 8'h26);
    check("R7 tx_req pulse", tx_req, 1'b1);
    rd(4'h7, v); check("R7 tx ok status", v, 8'h02);
    check("R7 tx_req one cycle", tx_req, 1'b0);
    check("R3 irq on tx ok", irq, 1'b1);
    rd(4'h0, v); check("R7 command bit2 cleared", v, 8'h22);
    rd(4'h4, v); check("R7 tx status", v, 8'h01);
    wr(4'h7, 8'hFF);
    wr(4'h0, 8'h25);
    check("R7 no tx when stopped", tx_req, 1'b0);
    rd(4'h7, v); check("R7 no tx ok when stopped", v, 8'h00);
    rd(4'h0, v); check("R7 stored as written", v, 8'h25);
    wr(4'h0, 8'h22);

    // R4 event sets and collisions
    pulse_evt(8'h10);
    rd(4'h7, v); check("R4 event set", v, 8'h10);
    check("R3 irq on overwrite", irq, 1'b1);
    wr(4'hF, 8'h00);
    check("R3 masked irq", irq, 1'b0);
    wr(4'hF, 8'hFF);
    wr_evt(4'h7, 8'h01, 8'h01);
    rd(4'h7, v); check("R4 set wins over clear", v, 8'h11);
    pulse_evt(8'h80);
    wr(4'h7, 8'hFF);
    rd(4'h7, v); check("R4 bit7 not cleared by write", v, 8'h80);
    check("R3 bit7 alone no irq", irq, 1'b0);

    // R10 configuration bytes
    wr(4'hC, 8'h0C); wr(4'hE, 8'h01);
    check("R10 rx_cfg", rx_cfg, 8'h0C);
    check("R10 data_cfg", data_cfg, 8'h01);
    rd(4'hC, v); check("R10 offset 12 reads zero", v, 8'h00);

    summary();
    $finish;
  end
endmodule